// File: doc/BRIEF.md
# Multi-Width UART FIFO Access Port

This block sits on the host side of one UART channel. It holds the channel's 64-byte receive FIFO, with an error tag stored next to each received byte, and its 64-byte transmit FIFO. A host reaches both FIFOs through a register-style bus. A single read or write can move one, two, three or four bytes, so a full receive FIFO empties in a short run of word reads.

Reads from the data window pop bytes from the receive FIFO. Writes to the same window push bytes into the transmit FIFO. A second window returns each received byte with its error tag in the same access, so the host needs no separate status read. A byte-wide holding register at offset zero keeps the classic one-byte-per-access path.

The serial side is modelled by two plain strobes. One loads the receive FIFO and one drains the transmit FIFO.

Top module: `uart_fifo_port`

## Requirements
- R1: After reset, both fill counts, both error flags and the read data are zero.
- R2: A read of the data window (0x100 to 0x13F) with size code s (0 to 3) pops s+1 bytes. The oldest byte is in bits 7:0, and each younger byte is in the next byte lane up. The result appears on `rd_data` one clock after the strobe, and `rx_level` falls by the number of bytes popped.
- R3: When a read asks for more bytes than the receive FIFO holds, only the bytes present are popped. The lanes with no byte read as zero, and `rd_underflow` is high for one cycle.
- R4: A write to the data window with size code s pushes s+1 bytes of `wr_data` into the transmit FIFO, bits 7:0 first. `tx_out` shows the oldest transmit byte, and `tx_take` removes it.
- R5: When a write holds more bytes than the transmit FIFO has room for, bytes are accepted in lane order until the FIFO is full and the rest are dropped. `wr_overflow` is high for one cycle.
- R6: A read of the paired window (0x180 to 0x1FF) with size code 0 or 1 pops one byte. It returns the data byte in bits 7:0 and that byte's error tag in bits 15:8.
- R7: A paired-window read with size code 2 or 3 pops two bytes and returns two data/tag pairs. The older pair is in bits 15:0.
- R8: At offset 0x000, a read pops exactly one byte into bits 7:0 and a write pushes exactly bits 7:0, whatever the size code.
- R9: `rx_level` and `tx_level` stay within 0 to 64. A receive load that arrives when the FIFO is full is dropped.
- R10: A full 64-byte receive FIFO drains in sixteen 32-bit data-window reads.
- R11: Reads and writes at any other offset change no FIFO. Such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte offset of the access |
| bus_size | input | 2 | Access size code: bytes moved = code + 1 |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 32 | Write data, oldest byte in bits 7:0 |
| rd_data | output | 32 | Registered read data |
| rx_load | input | 1 | Load one received byte |
| rx_load_data | input | 8 | Received byte |
| rx_load_tag | input | 8 | Error tag for that byte |
| tx_take | input | 1 | Remove the oldest transmit byte |
| tx_out | output | 8 | Oldest transmit byte |
| rx_level | output | 7 | Receive FIFO fill count |
| tx_level | output | 7 | Transmit FIFO fill count |
| rd_underflow | output | 1 | Last read asked for more bytes than were held |
| wr_overflow | output | 1 | Last write had bytes dropped |

## Verification
The assertions assume that a receive load never arrives in the same cycle as a bus read, and that a transmit take never arrives in the same cycle as a bus write. Under those conditions an underflow must leave the receive FIFO empty, and an overflow must leave the transmit FIFO full. The stimulus keeps to this: its tasks for loading, taking, reading and writing never overlap, and each one returns the strobes low before the next begins. Strobes are held for a single cycle, which matches the assertion that a count can only move when its own side is active.

// File: rtl/uart_fifo_port.sv
module uart_fifo_port #(
  parameter int DEPTH = 64,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  input  logic          rx_load,
  input  logic [7:0]    rx_load_data,
  input  logic [7:0]    rx_load_tag,
  input  logic          tx_take,
  output logic [7:0]    tx_out,
  output logic [$clog2(DEPTH):0] rx_level,
  output logic [$clog2(DEPTH):0] tx_level,
  output logic          rd_underflow,
  output logic          wr_overflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [15:0]   rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] rx_rp, rx_wp, tx_rp, tx_wp;

  wire win_hold = (bus_addr == '0);
  wire win_data = (bus_addr[AW-1:6] == (AW-6)'(4));
  wire win_pair = (bus_addr[AW-1:7] == (AW-7)'(3));

  logic [2:0] rd_n, wr_n, rd_got, wr_got;
  logic [CW-1:0] tx_room;
  logic [31:0] rd_word;

  always_comb begin
    rd_n = 3'd0;
    if (bus_rd) begin
      if (win_hold)      rd_n = 3'd1;
      else if (win_data) rd_n = {1'b0, bus_size} + 3'd1;
      else if (win_pair) rd_n = bus_size[1] ? 3'd2 : 3'd1;
    end
    wr_n = 3'd0;
    if (bus_wr) begin
      if (win_hold)      wr_n = 3'd1;
      else if (win_data) wr_n = {1'b0, bus_size} + 3'd1;
    end
  end

  assign tx_room = FULL - tx_level;
  assign rd_got  = (CW'(rd_n) > rx_level) ? rx_level[2:0] : rd_n;
  assign wr_got  = (CW'(wr_n) > tx_room) ? tx_room[2:0] : wr_n;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < rd_got) begin
        if (win_pair) begin
          if (i < 2) rd_word[16*i +: 16] = rx_mem[rx_rp + PW'(i)];
        end else begin
          rd_word[8*i +: 8] = rx_mem[rx_rp + PW'(i)][7:0];
        end
      end
    end
  end

  wire rx_in = rx_load && (rx_level != FULL);
  wire tx_out_ok = tx_take && (tx_level != '0);
  assign tx_out = tx_mem[tx_rp];

  always_ff @(posedge clk) begin
    if (rx_in) rx_mem[rx_wp] <= {rx_load_tag, rx_load_data};
    for (int i = 0; i < 4; i++)
      if (3'(i) < wr_got) tx_mem[tx_wp + PW'(i)] <= wr_data[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; tx_rp <= '0; tx_wp <= '0;
      rx_level <= '0; tx_level <= '0;
      rd_data <= '0; rd_underflow <= 1'b0; wr_overflow <= 1'b0;
    end else begin
      rx_wp    <= rx_wp + PW'(rx_in);
      rx_rp    <= rx_rp + PW'(rd_got);
      rx_level <= rx_level + CW'(rx_in) - CW'(rd_got);
      tx_wp    <= tx_wp + PW'(wr_got);
      tx_rp    <= tx_rp + PW'(tx_out_ok);
      tx_level <= tx_level + CW'(wr_got) - CW'(tx_out_ok);
      if (bus_rd) rd_data <= rd_word;
      rd_underflow <= (rd_got != rd_n);
      wr_overflow  <= (wr_got != wr_n);
    end
  end

  a_r9_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rx_level <= FULL);
  a_r9_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tx_level <= FULL);
  a_r3_under_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_underflow |-> $past(bus_rd));
  a_r5_over_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overflow |-> $past(bus_wr));
  a_r3_under_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_underflow && !$past(rx_load)) |-> rx_level == '0);
  a_r5_over_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_overflow && !$past(tx_take)) |-> tx_level == FULL);
  a_r11_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !rx_load) |=> $stable(rx_level));
  a_r4_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !tx_take) |=> $stable(tx_level));
  a_r2_pop_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_load |=> (int'($past(rx_level)) - int'(rx_level)) <= 4);
endmodule

// File: tb/uart_fifo_port_tb_top.sv
module uart_fifo_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rx_load = 1'b0;
  logic [7:0] rx_load_data = '0, rx_load_tag = '0;
  logic tx_take = 1'b0;
  logic [7:0] tx_out;
  logic [6:0] rx_level, tx_level;
  logic rd_underflow, wr_overflow;
  int checks = 0, fails = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  uart_fifo_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .wr_data(wr_data), .rd_data(rd_data),
    .rx_load(rx_load), .rx_load_data(rx_load_data), .rx_load_tag(rx_load_tag),
    .tx_take(tx_take), .tx_out(tx_out), .rx_level(rx_level), .tx_level(tx_level),
    .rd_underflow(rd_underflow), .wr_overflow(wr_overflow));

  // {bytes loaded, first byte, size code, expected rd_data, expected underflow, expected rx_level}
  localparam logic [57:0] VEC [7] = '{
    {8'd4, 8'h10, 2'd3, 32'h13121110, 1'b0, 7'd0},
    {8'd2, 8'h20, 2'd1, 32'h00002120, 1'b0, 7'd0},
    {8'd3, 8'h30, 2'd2, 32'h00323130, 1'b0, 7'd0},
    {8'd1, 8'h40, 2'd0, 32'h00000040, 1'b0, 7'd0},
    {8'd2, 8'h50, 2'd3, 32'h00005150, 1'b1, 7'd0},
    {8'd5, 8'h60, 2'd0, 32'h00000060, 1'b0, 7'd4},
    {8'd0, 8'h00, 2'd3, 32'h00000000, 1'b1, 7'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_load = 1'b1; rx_load_data = base + 8'(i); rx_load_tag = ~(base + 8'(i));
    end
    @(negedge clk); rx_load = 1'b0;
  endtask

  task automatic bread(input logic [9:0] a, input logic [1:0] s);
    @(negedge clk); bus_addr = a; bus_size = s; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic bwrite(input logic [9:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_size = s; wr_data = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic take(output logic [7:0] b);
    @(negedge clk); b = tx_out; tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rx_level", 32'(rx_level), 0);
    check("R1 tx_level", 32'(tx_level), 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 flags", {30'd0, rd_underflow, wr_overflow}, 0);
    rst_n = 1'b1;

    // R2 and R3 vector walk on the data window
    for (int v = 0; v < 7; v++) begin
      load(int'(VEC[v][57:50]), VEC[v][49:42]);
      bread(10'h100, VEC[v][41:40]);
      check($sformatf("R2/R3 vec%0d data", v), rd_data, VEC[v][39:8]);
      check($sformatf("R3 vec%0d underflow", v), 32'(rd_underflow), 32'(VEC[v][7]));
      check($sformatf("R2 vec%0d level", v), 32'(rx_level), 32'(VEC[v][6:0]));
      while (rx_level != 0) bread(10'h13C, 2'd3);
    end

    // R6 and R7: data paired with tag, tag = inverted data
    load(3, 8'hA0);
    bread(10'h180, 2'd3);
    check("R7 two pairs", rd_data, 32'h5EA15FA0);
    check("R7 level", 32'(rx_level), 1);
    bread(10'h1FE, 2'd1);
    check("R6 one pair", rd_data, 32'h00005DA2);
    check("R6 level", 32'(rx_level), 0);

    // R8 holding register
    load(2, 8'hB0);
    bread(10'h000, 2'd3);
    check("R8 read one byte", rd_data, 32'h000000B0);
    check("R8 read level", 32'(rx_level), 1);
    bwrite(10'h000, 2'd3, 32'hDDCCBBAA);
    check("R8 write level", 32'(tx_level), 1);
    take(got);
    check("R8 write byte", 32'(got), 32'hAA);
    bread(10'h000, 2'd0);

    // R11 unmapped offset
    load(2, 8'hC0);
    bread(10'h040, 2'd3);
    check("R11 read zero", rd_data, 0);
    check("R11 rx unchanged", 32'(rx_level), 2);
    bwrite(10'h2C0, 2'd3, 32'h01020304);
    check("R11 tx unchanged", 32'(tx_level), 0);
    bread(10'h100, 2'd1);

    // R4 transmit order
    bwrite(10'h104, 2'd1, 32'h99882211);
    check("R4 level", 32'(tx_level), 2);
    check("R4 no overflow", 32'(wr_overflow), 0);
    take(got); check("R4 first byte", 32'(got), 32'h11);
    take(got); check("R4 second byte", 32'(got), 32'h22);

    // R5 transmit overflow
    for (int i = 0; i < 16; i++)
      bwrite(10'h100, 2'd3, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    check("R5 full", 32'(tx_level), 64);
    take(got); take(got);
    bwrite(10'h100, 2'd3, 32'hEEDDCCBB);
    check("R5 overflow flag", 32'(wr_overflow), 1);
    check("R5 level capped", 32'(tx_level), 64);
    for (int i = 0; i < 62; i++) take(got);
    take(got); check("R5 kept lane0", 32'(got), 32'hBB);
    take(got); check("R5 kept lane1", 32'(got), 32'hCC);
    check("R5 empty after", 32'(tx_level), 0);

    // R9 and R10 receive full and drain
    load(65, 8'h00);
    check("R9 level capped", 32'(rx_level), 64);
    for (int i = 0; i < 16; i++) begin
      bread(10'h100, 2'd3);
      check($sformatf("R10 word %0d", i), rd_data,
            {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
    end
    check("R10 drained", 32'(rx_level), 0);
    bread(10'h100, 2'd3);
    check("R3 empty underflow", 32'(rd_underflow), 1);
    check("R3 empty data", rd_data, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule